// File: doc/BRIEF.md
# Codec Host Sample Port with Format Conversion

This block sits between a host that moves audio samples by programmed I/O and the 16-bit linear sample path inside an audio codec. Playback bytes written by the host are gathered into a frame, converted to 16-bit two's-complement and handed to the converter side when it strobes a sample request. Captured 16-bit samples are converted to the selected host format and read back byte by byte.

The host sees four byte addresses: 0 is an index register, 1 is the data window of the indexed register, 2 is the sample data port (write for playback, read for capture) and 3 is unused. Behind the index sit a format register and a status register. Each side of the converter issues a one-cycle request strobe once per sample period. While the codec reports that it is initialising, the host is locked out of the index and sample data registers, which read back fixed values.

Top module: `codec_pio_port`

## Requirements
- R1: After reset the index register reads 40h, the format register reads 00h (8-bit unsigned, mono), the status register reads 00h and both playback outputs are 0000h.
- R2: While init_busy is high, address 0 reads 80h and ignores writes, address 2 reads 80h without consuming a capture byte, and writes to address 2 are discarded.
- R3: The low nibble of the index selects the indirect register at address 1: 0 is the format register (bits 2:0 format code, bit 3 stereo when 1), 1 is the status register (bit 0 capture overrun, bit 1 playback underrun); any other index and address 3 read 00h.
- R4: Format code 000 is 8-bit unsigned: a playback byte b becomes {~b[7], b[6:0], 8'h00}, and a capture sample s becomes {~s[15], s[14:8]}.
- R5: Format code 001 expands each playback byte with the mu-law rule (byte FFh gives 0000h, byte 00h gives 8284h).
- R6: Format code 001 compresses each capture sample with the mu-law rule, magnitudes above 32635 clipped (0000h gives FFh, 8000h gives 00h).
- R7: Format code 010, and every code from 011 to 111, is 16-bit two's complement sent low byte first; stereo frames carry left then right; in mono the right output copies the left.
- R8: A playback frame (1, 2 or 4 bytes by format and stereo) is delivered on play_l/play_r at the first play_req after its last byte; data writes while a complete frame waits are discarded.
- R9: A play_req with no complete frame sets the underrun bit and leaves play_l and play_r unchanged.
- R10: A cap_req while no capture frame is held latches the converted frame; reading its last byte releases it, a cap_req in the same cycle as that last read is accepted, and a read with no frame held returns 00h.
- R11: A cap_req while a frame is still held drops the new sample, keeps the held bytes unchanged and sets the overrun bit.
- R12: Writing 1 to a status bit clears it, writing 0 leaves it, and a new event in the same cycle as a clear keeps the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_busy | input | 1 | Codec initialisation in progress |
| host_addr | input | 2 | Host byte address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (capture reads advance on it) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for host_addr |
| play_req | input | 1 | Converter needs a playback sample |
| play_l | output | 16 | Playback left sample |
| play_r | output | 16 | Playback right sample |
| cap_req | input | 1 | New capture sample present |
| cap_l | input | 16 | Capture left sample |
| cap_r | input | 16 | Capture right sample |

## Verification
The bench targets the mu-law extremes (zero, full negative scale above the clip point, the largest expanded code), where a wrong bias or clip gives off-by-one codes or a wrapped sign. It drives a capture request in the very cycle the last byte is read, which a design with the wrong priority turns into a spurious overrun, and holds a capture frame across an overrun to catch designs that overwrite the unread sample. It also hits a status clear and a new underrun in one cycle, and host accesses during initialisation, where a leaky lockout would shift the byte order of the following frame.

// File: rtl/cpp_pkg.sv
package cpp_pkg;
    localparam int BYTE_W    = 8;
    localparam int SAMP_W    = 16;
    localparam int FRAME_MAX = 4;
    localparam int CHANS     = 2;
    localparam int ULAW_BIAS = 132;
    localparam int ULAW_CLIP = 32635;

    localparam logic [2:0] FMT_U8   = 3'd0;
    localparam logic [2:0] FMT_ULAW = 3'd1;
    localparam logic [2:0] FMT_S16  = 3'd2;

    localparam logic [BYTE_W-1:0] IDX_RST   = 8'h40;
    localparam logic [BYTE_W-1:0] LOCK_READ = 8'h80;

    typedef struct packed {
        logic       stereo;
        logic [2:0] code;
    } fmt_cfg_t;

    typedef logic [FRAME_MAX-1:0][BYTE_W-1:0] frame_t;

    function automatic logic is_wide(logic [2:0] c);
        return !(c == FMT_U8 || c == FMT_ULAW);
    endfunction

    function automatic logic [2:0] frame_len(fmt_cfg_t f);
        logic [2:0] n;
        n = is_wide(f.code) ? 3'd2 : 3'd1;
        if (f.stereo) n = n << 1;
        return n;
    endfunction

    function automatic logic [SAMP_W-1:0] ulaw_expand(logic [BYTE_W-1:0] cw);
        logic [BYTE_W-1:0] u;
        logic [SAMP_W-1:0] t;
        u = ~cw;
        t = {8'd0, 1'b0, u[3:0], 3'b000} + 16'(ULAW_BIAS);
        t = t << u[6:4];
        t = t - 16'(ULAW_BIAS);
        return u[7] ? (~t + 16'd1) : t;
    endfunction

    function automatic logic [BYTE_W-1:0] ulaw_compress(logic [SAMP_W-1:0] s);
        logic [SAMP_W-1:0] m;
        logic [2:0]        e;
        logic [3:0]        mt;
        m = s[15] ? (~s + 16'd1) : s;
        if (m > 16'(ULAW_CLIP)) m = 16'(ULAW_CLIP);
        m = m + 16'(ULAW_BIAS);
        casez (m[14:7])
            8'b1???????: e = 3'd7;
            8'b01??????: e = 3'd6;
            8'b001?????: e = 3'd5;
            8'b0001????: e = 3'd4;
            8'b00001???: e = 3'd3;
            8'b000001??: e = 3'd2;
            8'b0000001?: e = 3'd1;
            default:     e = 3'd0;
        endcase
        mt = m[{1'b0, e} + 4'd3 +: 4];
        return ~{s[15], e, mt};
    endfunction

    function automatic logic [SAMP_W-1:0] to_lin(logic [2:0] c, logic [BYTE_W-1:0] b);
        if (c == FMT_ULAW) return ulaw_expand(b);
        return {~b[7], b[6:0], 8'h00};
    endfunction

    function automatic logic [BYTE_W-1:0] to_byte(logic [2:0] c, logic [SAMP_W-1:0] s);
        if (c == FMT_ULAW) return ulaw_compress(s);
        return {~s[15], s[14:8]};
    endfunction
endpackage

// File: rtl/cpp_ctrl.sv
module cpp_ctrl
    import cpp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              init_busy,
    input  logic              host_wr,
    input  logic [1:0]        host_addr,
    input  logic [BYTE_W-1:0] host_wdata,
    input  logic              ovr_set,
    input  logic              unr_set,
    output fmt_cfg_t          cfg,
    output logic [BYTE_W-1:0] reg_rdata
);
    logic [BYTE_W-1:0] idx_q;
    fmt_cfg_t          cfg_q;
    logic              ovr_q, unr_q;
    logic              wr_idx, wr_ind, clr_stat;
    logic [3:0]        sel;

    assign sel      = idx_q[3:0];
    assign wr_idx   = host_wr && host_addr == 2'd0 && !init_busy;
    assign wr_ind   = host_wr && host_addr == 2'd1;
    assign clr_stat = wr_ind && sel == 4'd1;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= IDX_RST;
            cfg_q <= '0;
            ovr_q <= 1'b0;
            unr_q <= 1'b0;
        end else begin
            if (wr_idx) idx_q <= host_wdata;
            if (wr_ind && sel == 4'd0) cfg_q <= fmt_cfg_t'(host_wdata[3:0]);
            ovr_q <= ovr_set | (ovr_q & ~(clr_stat & host_wdata[0]));
            unr_q <= unr_set | (unr_q & ~(clr_stat & host_wdata[1]));
        end
    end

    assign cfg = cfg_q;

    always_comb begin
        reg_rdata = '0;
        if (host_addr == 2'd0) begin
            reg_rdata = init_busy ? LOCK_READ : idx_q;
        end else if (host_addr == 2'd1) begin
            case (sel)
                4'd0:    reg_rdata = {4'd0, cfg_q};
                4'd1:    reg_rdata = {6'd0, unr_q, ovr_q};
                default: reg_rdata = '0;
            endcase
        end
    end

    // R2
    init_idx_chk: assert property (@(posedge clk) disable iff (rst)
        init_busy && host_wr && host_addr == 2'd0 |=> $stable(idx_q));
    // R12
    ovr_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        ovr_set |=> ovr_q);
    // R12
    unr_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        unr_set |=> unr_q);
endmodule

// File: rtl/cpp_play.sv
module cpp_play
    import cpp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  fmt_cfg_t          cfg,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              play_req,
    output logic [SAMP_W-1:0] play_l,
    output logic [SAMP_W-1:0] play_r,
    output logic              unr_set
);
    frame_t            bytes_q;
    logic [1:0]        wptr_q;
    logic              full_q;
    logic [SAMP_W-1:0] lin [CHANS];

    for (genvar ch = 0; ch < CHANS; ch++) begin : g_ch
        assign lin[ch] = is_wide(cfg.code) ? {bytes_q[2*ch+1], bytes_q[2*ch]}
                                           : to_lin(cfg.code, bytes_q[ch]);
    end

    assign unr_set = play_req && !full_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bytes_q <= '0;
            wptr_q  <= '0;
            full_q  <= 1'b0;
            play_l  <= '0;
            play_r  <= '0;
        end else begin
            if (wr_en && !full_q) begin
                bytes_q[wptr_q] <= wdata;
                if ({1'b0, wptr_q} + 3'd1 == frame_len(cfg)) begin
                    wptr_q <= '0;
                    full_q <= 1'b1;
                end else begin
                    wptr_q <= wptr_q + 2'd1;
                end
            end
            if (play_req && full_q) begin
                play_l <= lin[0];
                play_r <= cfg.stereo ? lin[1] : lin[0];
                full_q <= 1'b0;
            end
        end
    end

    // R9
    unr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        play_req && !full_q |=> $stable(play_l) && $stable(play_r));
    // R8
    handoff_chk: assert property (@(posedge clk) disable iff (rst)
        play_req && full_q |=> !full_q);
    // R8
    full_block_chk: assert property (@(posedge clk) disable iff (rst)
        full_q && wr_en |=> $stable(bytes_q));
endmodule

// File: rtl/cpp_capt.sv
module cpp_capt
    import cpp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  fmt_cfg_t          cfg,
    input  logic              cap_req,
    input  logic [SAMP_W-1:0] cap_l,
    input  logic [SAMP_W-1:0] cap_r,
    input  logic              rd_en,
    output logic [BYTE_W-1:0] rbyte,
    output logic              ovr_set
);
    frame_t            buf_q, enc;
    logic              held_q;
    logic [1:0]        rptr_q;
    logic [2:0]        len_q;
    logic              last_rd, free;
    logic [SAMP_W-1:0] samp_r;

    assign samp_r = cfg.stereo ? cap_r : cap_l;

    always_comb begin
        if (is_wide(cfg.code))
            enc = {samp_r[15:8], samp_r[7:0], cap_l[15:8], cap_l[7:0]};
        else
            enc = {8'h00, 8'h00, to_byte(cfg.code, samp_r), to_byte(cfg.code, cap_l)};
    end

    assign last_rd = rd_en && held_q && ({1'b0, rptr_q} + 3'd1 == len_q);
    assign free    = !held_q || last_rd;
    assign ovr_set = cap_req && !free;
    assign rbyte   = held_q ? buf_q[rptr_q] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q  <= '0;
            held_q <= 1'b0;
            rptr_q <= '0;
            len_q  <= 3'd1;
        end else begin
            if (rd_en && held_q) begin
                if (last_rd) begin
                    held_q <= 1'b0;
                    rptr_q <= '0;
                end else begin
                    rptr_q <= rptr_q + 2'd1;
                end
            end
            if (cap_req && free) begin
                buf_q  <= enc;
                held_q <= 1'b1;
                rptr_q <= '0;
                len_q  <= frame_len(cfg);
            end
        end
    end

    // R11
    ovr_keep_chk: assert property (@(posedge clk) disable iff (rst)
        cap_req && held_q && !last_rd |=> $stable(buf_q) && held_q);
    // R10
    rd_free_chk: assert property (@(posedge clk) disable iff (rst)
        last_rd && !cap_req |=> !held_q);
endmodule

// File: rtl/codec_pio_port.sv
module codec_pio_port
    import cpp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              init_busy,
    input  logic [1:0]        host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic              play_req,
    output logic [15:0]       play_l,
    output logic [15:0]       play_r,
    input  logic              cap_req,
    input  logic [15:0]       cap_l,
    input  logic [15:0]       cap_r
);
    fmt_cfg_t          cfg;
    logic [BYTE_W-1:0] reg_rdata, cap_byte;
    logic              ovr_set, unr_set;
    logic              data_sel, pb_wr, cp_rd;

    assign data_sel = host_addr == 2'd2;
    assign pb_wr    = host_wr && data_sel && !init_busy;
    assign cp_rd    = host_rd && data_sel && !init_busy;

    cpp_ctrl u_ctrl (
        .clk(clk), .rst(rst), .init_busy(init_busy), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .ovr_set(ovr_set),
        .unr_set(unr_set), .cfg(cfg), .reg_rdata(reg_rdata)
    );

    cpp_play u_play (
        .clk(clk), .rst(rst), .cfg(cfg), .wr_en(pb_wr), .wdata(host_wdata),
        .play_req(play_req), .play_l(play_l), .play_r(play_r), .unr_set(unr_set)
    );

    cpp_capt u_capt (
        .clk(clk), .rst(rst), .cfg(cfg), .cap_req(cap_req), .cap_l(cap_l),
        .cap_r(cap_r), .rd_en(cp_rd), .rbyte(cap_byte), .ovr_set(ovr_set)
    );

    always_comb begin
        case (host_addr)
            2'd0, 2'd1: host_rdata = reg_rdata;
            2'd2:       host_rdata = init_busy ? LOCK_READ : cap_byte;
            default:    host_rdata = '0;
        endcase
    end
endmodule

// File: tb/sim_codec_pio_port.sv
`timescale 1ns/100ps
module sim_codec_pio_port;
    logic        clk = 0, rst = 1, init_busy = 0;
    logic [1:0]  host_addr = 0;
    logic        host_wr = 0, host_rd = 0;
    logic [7:0]  host_wdata = 0;
    logic [7:0]  host_rdata;
    logic        play_req = 0, cap_req = 0;
    logic [15:0] play_l, play_r, cap_l = 0, cap_r = 0;
    int checks = 0, failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    codec_pio_port u0 (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hwr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1;
        @(negedge clk); host_wr = 0;
    endtask

    task automatic hrd(input logic [1:0] a, output int v);
        @(negedge clk); host_addr = a; host_rd = 1;
        #1 v = int'(host_rdata);
        @(negedge clk); host_rd = 0;
    endtask

    task automatic play_pulse();
        @(negedge clk); play_req = 1;
        @(negedge clk); play_req = 0;
    endtask

    task automatic cap_pulse(input logic [15:0] l, input logic [15:0] r);
        @(negedge clk); cap_l = l; cap_r = r; cap_req = 1;
        @(negedge clk); cap_req = 0;
    endtask

    task automatic set_cfg(input int code, input int st);
        hwr(2'd0, 8'h40);
        hwr(2'd1, 8'((st << 3) | code));
    endtask

    task automatic read_stat(output int v);
        hwr(2'd0, 8'h41);
        hrd(2'd1, v);
    endtask

    function automatic int m_expand(input int cw);
        int u, e, m, mag;
        u = (~cw) & 255; e = (u >> 4) & 7; m = u & 15;
        mag = ((m * 8) + 132) * (1 << e) - 132;
        return (u & 128) ? ((-mag) & 16'hFFFF) : mag;
    endfunction

    function automatic int m_compress(input int s);
        int v, sg, mag, e, m;
        v = (s > 32767) ? s - 65536 : s;
        sg = (v < 0) ? 1 : 0;
        mag = sg ? -v : v;
        if (mag > 32635) mag = 32635;
        mag += 132;
        e = 7;
        while (e > 0 && ((mag >> (e + 7)) & 1) == 0) e--;
        m = (mag >> (e + 3)) & 15;
        return (~((sg << 7) | (e << 4) | m)) & 255;
    endfunction

    function automatic int m_to16(input int code, input int b);
        if (code == 1) return m_expand(b);
        return ((b ^ 128) << 8) & 16'hFFFF;
    endfunction

    function automatic int m_from16(input int code, input int s);
        if (code == 1) return m_compress(s);
        return ((s >> 8) ^ 128) & 255;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int v, seed;
        seed = $urandom(1357);
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        hrd(2'd0, v); chk("R1 index", v, 8'h40);
        hrd(2'd1, v); chk("R1 format", v, 8'h00);
        read_stat(v); chk("R1 status", v, 8'h00);
        chk("R1 play_l", int'(play_l), 0);
        // R3 other indexes and address 3
        hwr(2'd0, 8'h45); hrd(2'd1, v); chk("R3 idx5", v, 0);
        hrd(2'd3, v); chk("R3 addr3", v, 0);
        set_cfg(3, 1); hrd(2'd1, v); chk("R3 format rb", v, 8'h0B);
        // R4 unsigned 8-bit
        set_cfg(0, 0);
        hwr(2'd2, 8'h00); play_pulse(); chk("R4 u8 00", int'(play_l), 16'h8000);
        chk("R7 mono copy", int'(play_r), 16'h8000);
        hwr(2'd2, 8'hFF); play_pulse(); chk("R4 u8 FF", int'(play_l), 16'h7F00);
        cap_pulse(16'h1234, 0); hrd(2'd2, v); chk("R4 cap u8", v, 8'h92);
        // R10 read with nothing held
        hrd(2'd2, v); chk("R10 empty read", v, 0);
        // R8 writes while full are dropped
        hwr(2'd2, 8'h10); hwr(2'd2, 8'h20); play_pulse();
        chk("R8 first frame", int'(play_l), 16'h9000);
        // R9 underrun holds output
        play_pulse(); chk("R9 hold", int'(play_l), 16'h9000);
        read_stat(v); chk("R9 unr bit", v, 8'h02);
        // R12 write 0 keeps, write 1 clears
        hwr(2'd1, 8'h00); hrd(2'd1, v); chk("R12 w0 keeps", v, 8'h02);
        hwr(2'd1, 8'h02); hrd(2'd1, v); chk("R12 w1 clears", v, 8'h00);
        // R12 set wins over clear
        hwr(2'd1, 8'h02); // clear with nothing set
        @(negedge clk); host_addr = 1; host_wdata = 8'h02; host_wr = 1; play_req = 1;
        @(negedge clk); host_wr = 0; play_req = 0;
        hrd(2'd1, v); chk("R12 set wins", v, 8'h02);
        hwr(2'd1, 8'h03);
        // R11 overrun keeps held sample
        cap_pulse(16'h1234, 0); cap_pulse(16'h5600, 0);
        hrd(2'd1, v); chk("R11 ovr bit", v, 8'h01);
        hrd(2'd2, v); chk("R11 kept byte", v, 8'h92);
        hwr(2'd1, 8'h01);
        // R10 capture accepted in the cycle of the last read
        cap_pulse(16'h1100, 0);
        @(negedge clk); host_addr = 2; host_rd = 1; cap_l = 16'h2200; cap_req = 1;
        #1 v = int'(host_rdata); chk("R10 old byte", v, 8'h91);
        @(negedge clk); host_rd = 0; cap_req = 0;
        hrd(2'd2, v); chk("R10 new byte", v, 8'hA2);
        read_stat(v); chk("R10 no overrun", v, 8'h00);
        // R2 initialisation lockout
        cap_pulse(16'h3300, 0);
        @(negedge clk); init_busy = 1;
        hrd(2'd0, v); chk("R2 index 80", v, 8'h80);
        hwr(2'd0, 8'h40); hrd(2'd0, v); chk("R2 index wr", v, 8'h80);
        hrd(2'd2, v); chk("R2 cap 80", v, 8'h80);
        hwr(2'd2, 8'h55);
        @(negedge clk); init_busy = 0;
        hrd(2'd0, v); chk("R2 index kept", v, 8'h41);
        hrd(2'd2, v); chk("R2 cap not consumed", v, 8'hB3);
        play_pulse(); hrd(2'd1, v); chk("R2 pb write dropped", v, 8'h02);
        hwr(2'd1, 8'h03);
        // R5 R6 mu-law corners
        set_cfg(1, 0);
        hwr(2'd2, 8'hFF); play_pulse(); chk("R5 FF", int'(play_l), 0);
        hwr(2'd2, 8'h00); play_pulse(); chk("R5 00", int'(play_l), 16'h8284);
        cap_pulse(16'h0000, 0); hrd(2'd2, v); chk("R6 zero", v, 8'hFF);
        cap_pulse(16'h8000, 0); hrd(2'd2, v); chk("R6 clip", v, 8'h00);
        // R7 16-bit stereo order
        set_cfg(2, 1);
        hwr(2'd2, 8'h34); hwr(2'd2, 8'h12); hwr(2'd2, 8'h78); hwr(2'd2, 8'h56);
        play_pulse(); chk("R7 left", int'(play_l), 16'h1234);
        chk("R7 right", int'(play_r), 16'h5678);
        // random mix, all requirements R4 R5 R6 R7 R8 R10
        for (int it = 0; it < 60; it++) begin
            int code, st, el, er, bl, br, cl, cr, nb;
            int exp_b [4];
            code = $urandom_range(0, 7); st = $urandom_range(0, 1);
            set_cfg(code, st);
            if (code > 1) begin
                el = $urandom & 16'hFFFF; er = $urandom & 16'hFFFF;
                hwr(2'd2, 8'(el)); hwr(2'd2, 8'(el >> 8));
                if (st) begin hwr(2'd2, 8'(er)); hwr(2'd2, 8'(er >> 8)); end
            end else begin
                bl = $urandom & 255; br = $urandom & 255;
                hwr(2'd2, 8'(bl)); if (st) hwr(2'd2, 8'(br));
                el = m_to16(code, bl); er = m_to16(code, br);
            end
            if (!st) er = el;
            play_pulse();
            chk("R7 rnd play_l", int'(play_l), el);
            chk("R7 rnd play_r", int'(play_r), er);
            cl = $urandom & 16'hFFFF; cr = $urandom & 16'hFFFF;
            if (code > 1) begin
                exp_b[0] = cl & 255; exp_b[1] = cl >> 8;
                exp_b[2] = cr & 255; exp_b[3] = cr >> 8;
                nb = st ? 4 : 2;
            end else begin
                exp_b[0] = m_from16(code, cl); exp_b[1] = m_from16(code, cr);
                exp_b[2] = 0; exp_b[3] = 0;
                nb = st ? 2 : 1;
            end
            cap_pulse(16'(cl), 16'(cr));
            for (int k = 0; k < nb; k++) begin
                hrd(2'd2, v); chk("R10 rnd cap byte", v, exp_b[k]);
            end
            hrd(2'd2, v); chk("R10 rnd drained", v, 0);
        end
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule